// File: doc/BRIEF.md
# Keyed Watchdog Timer with Paired Clear

This block is a watchdog for a small processor core. It counts timing ticks from one of three sources. A prescaler with a power-of-two ratio divides the ticks, and an 8-bit overflow counter follows it. When that counter wraps, the block reports a time-out. If the core is awake, the report is a one-cycle device reset. If the core is asleep, it is a one-cycle wake request together with a request to reset only the program counter and stack pointer. In both cases a sticky time-out flag is set.

Two controls decide whether the timer runs: a configuration force-enable input and a 4-bit key register that software writes. Only one key code stops the timer, and only while force-enable is low. Software keeps the timer from expiring with clear strobes. The strobe scheme is chosen by configuration:

- **Single mode:** one strobe clears the timer.
- **Paired mode:** two distinct strobes must alternate. Repeating the same strobe does nothing.

A HALT pulse and the active-low external reset also clear the timer. Everything runs on one system clock. The crystal and RC sources arrive as one-cycle tick enables, and the divided system clock is made internally.

Top module: `keyed_wdog`

## Requirements
- R1: The timer runs when `cfg_force_en` is 1, or when the key register differs from 4'b1010. It is stopped only when the key holds 4'b1010 and `cfg_force_en` is 0. The key resets to 4'b1010. A write (`key_we` with `key_wdata`) takes effect from the following cycle.
- R2: While the timer is stopped, the prescaler and counter are held at zero and no time-out output is raised. While stopped, the clear strobes change nothing, including the paired-mode tracker.
- R3: `cfg_src_sel` picks the tick source: 2'b00 = `xtal_tick`, 2'b01 = system clock divided by 4 (one tick in every fourth cycle), 2'b10 = `rc_tick`, 2'b11 = no ticks. The divided system clock gives no ticks while `asleep` is 1.
- R4: The prescaler select register resets to 3'b111 and is written with `ps_we` and `ps_wdata`. It sets the ratio to 2^sel, from 1:1 (3'b000) to 1:128 (3'b111). A time-out therefore falls on the 256·2^sel-th tick after a clear.
- R5: A time-out while `asleep` is 0 raises `dev_rst` for exactly one cycle, in the cycle after the overflowing tick, and sets `to_flag`.
- R6: A time-out while `asleep` is 1 raises `wake_req` and `pcsp_rst` together for one cycle, sets `to_flag`, and leaves `dev_rst` low.
- R7: `to_flag` stays set until `rst_n` goes low. `rst_n` asynchronously clears all state and outputs.
- R8: A `halt` pulse clears the prescaler and counter. It wins over a tick in the same cycle.
- R9: In single mode (`cfg_pair_mode` = 0), `clr_single` clears the prescaler and counter, and `clr_first` and `clr_second` are ignored.
- R10: In paired mode (`cfg_pair_mode` = 1):
  - `clr_single` is ignored.
  - The tracker starts, and returns after reset, in a state that accepts either strobe.
  - An accepted strobe clears the timer, after which only the other strobe clears.
  - A repeat of the same strobe is ignored, and so are both strobes together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous external reset |
| cfg_force_en | input | 1 | Configuration force-enable |
| cfg_pair_mode | input | 1 | 1 = paired clear strobes, 0 = single strobe |
| cfg_src_sel | input | 2 | Tick source select (see R3) |
| xtal_tick | input | 1 | Crystal-derived tick enable |
| rc_tick | input | 1 | RC-oscillator-derived tick enable |
| key_we | input | 1 | Key register write strobe |
| key_wdata | input | 4 | Key write data |
| ps_we | input | 1 | Prescaler select write strobe |
| ps_wdata | input | 3 | Prescaler select write data |
| clr_single | input | 1 | Single-mode clear strobe |
| clr_first | input | 1 | Paired-mode first clear strobe |
| clr_second | input | 1 | Paired-mode second clear strobe |
| halt | input | 1 | HALT executed, clears the timer |
| asleep | input | 1 | Core is in a low-power state |
| dev_rst | output | 1 | One-cycle full device reset request |
| wake_req | output | 1 | One-cycle wake request |
| pcsp_rst | output | 1 | One-cycle program counter and stack pointer reset request |
| to_flag | output | 1 | Sticky time-out status |

## Verification
Clears, HALT and strobes act on the same clock edge that samples them. Key and prescaler writes change the timer's behaviour from the next cycle. The time-out pulses and `to_flag` rise one clock after the edge that takes the counter past its maximum, so a time-out is visible 256·2^sel sampled edges after a clearing edge. The bench keeps a behavioural model that steps on the same rising edge as the design, and it compares every output at the following falling edge. Directed measurements count falling edges from a HALT to the reset pulse and check the exact 256 and 1024 counts for the crystal source. For the divided-clock and RC sources, whose phase is free-running, they check a one-tick window.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'b00,
        SRC_SYS4 = 2'b01,
        SRC_RC   = 2'b10,
        SRC_NONE = 2'b11
    } src_sel_e;

    typedef enum logic [1:0] {
        PAIR_ANY        = 2'b00,
        PAIR_SAW_FIRST  = 2'b01,
        PAIR_SAW_SECOND = 2'b10
    } pair_st_e;

endpackage

// File: rtl/kwd_cfg_regs.sv
module kwd_cfg_regs #(
    parameter int                KEY_W   = 4,
    parameter int                PS_W    = 3,
    parameter logic [KEY_W-1:0]  KEY_OFF = 4'b1010,
    parameter logic [KEY_W-1:0]  KEY_RST = 4'b1010,
    parameter logic [PS_W-1:0]   PS_RST  = 3'b111
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_force_en,
    input  logic             key_we,
    input  logic [KEY_W-1:0] key_wdata,
    input  logic             ps_we,
    input  logic [PS_W-1:0]  ps_wdata,
    output logic             run,
    output logic [PS_W-1:0]  ps_sel
);

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [PS_W-1:0]  ps;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (key_we) cfg_d.key = key_wdata;
        if (ps_we)  cfg_d.ps  = ps_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{key: KEY_RST, ps: PS_RST};
        else        cfg_q <= cfg_d;
    end

    assign run    = cfg_force_en | (cfg_q.key != KEY_OFF);
    assign ps_sel = cfg_q.ps;

    AST_KEY_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (key_we && key_wdata != KEY_OFF) |=> run); // R1

endmodule

// File: rtl/kwd_tick_sel.sv
module kwd_tick_sel
    import kwd_pkg::*;
#(
    parameter int DIV_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       xtal_tick,
    input  logic       rc_tick,
    input  logic       asleep,
    output logic       tick
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } div_t;

    div_t div_d, div_q;
    logic sys_tick;

    always_comb begin
        div_d     = div_q;
        div_d.div = div_q.div + 1'b1;
        sys_tick  = (div_q.div == {DIV_W{1'b1}}) && !asleep;
        case (src_sel_e'(src_sel))
            SRC_XTAL: tick = xtal_tick;
            SRC_SYS4: tick = sys_tick;
            SRC_RC:   tick = rc_tick;
            default:  tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    AST_SYS4_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_SYS4 && $past(src_sel) == SRC_SYS4 && tick) |=> !tick); // R3

    AST_SYS4_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_SYS4 && asleep) |-> !tick); // R3

endmodule

// File: rtl/kwd_clear_ctl.sv
module kwd_clear_ctl
    import kwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pair_mode,
    input  logic clr_single,
    input  logic clr_a,
    input  logic clr_b,
    output logic clr_go
);

    typedef struct packed {
        pair_st_e st;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d  = trk_q;
        clr_go = 1'b0;
        if (run) begin
            if (!pair_mode) begin
                clr_go = clr_single;
            end else if (clr_a ^ clr_b) begin
                if (clr_a && trk_q.st != PAIR_SAW_FIRST) begin
                    clr_go   = 1'b1;
                    trk_d.st = PAIR_SAW_FIRST;
                end
                if (clr_b && trk_q.st != PAIR_SAW_SECOND) begin
                    clr_go   = 1'b1;
                    trk_d.st = PAIR_SAW_SECOND;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '{st: PAIR_ANY};
        else        trk_q <= trk_d;
    end

    AST_PAIR_NO_REPEAT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pair_mode && clr_a && !clr_b) ##1 (run && pair_mode && clr_a && !clr_b) |-> !clr_go); // R10

    AST_PAIR_NO_REPEAT_B: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pair_mode && clr_b && !clr_a) ##1 (run && pair_mode && clr_b && !clr_a) |-> !clr_go); // R10

    AST_SINGLE_IGNORES_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_mode && !clr_single) |-> !clr_go); // R9

endmodule

// File: rtl/kwd_count.sv
module kwd_count #(
    parameter int CNT_W = 8,
    parameter int PS_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic            halt,
    input  logic            clr_go,
    input  logic            asleep,
    input  logic [PS_W-1:0] ps_sel,
    output logic            dev_rst,
    output logic            wake_req,
    output logic            pcsp_rst,
    output logic            to_flag
);

    localparam int PRE_W = (1 << PS_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             dev;
        logic             wake;
        logic             pcsp;
        logic             to;
    } wd_t;

    wd_t wd_d, wd_q;
    logic [PRE_W:0] lim;
    logic           roll;

    always_comb begin
        lim  = ({{PRE_W{1'b0}}, 1'b1} << ps_sel) - 1'b1;
        roll = ({1'b0, wd_q.pre} >= lim);
        wd_d      = wd_q;
        wd_d.dev  = 1'b0;
        wd_d.wake = 1'b0;
        wd_d.pcsp = 1'b0;
        if (!run || halt || clr_go) begin
            wd_d.pre = '0;
            wd_d.cnt = '0;
        end else if (tick) begin
            if (roll) begin
                wd_d.pre = '0;
                if (wd_q.cnt == {CNT_W{1'b1}}) begin
                    wd_d.cnt = '0;
                    wd_d.to  = 1'b1;
                    if (asleep) begin
                        wd_d.wake = 1'b1;
                        wd_d.pcsp = 1'b1;
                    end else begin
                        wd_d.dev  = 1'b1;
                    end
                end else begin
                    wd_d.cnt = wd_q.cnt + 1'b1;
                end
            end else begin
                wd_d.pre = wd_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign dev_rst  = wd_q.dev;
    assign wake_req = wd_q.wake;
    assign pcsp_rst = wd_q.pcsp;
    assign to_flag  = wd_q.to;

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !(dev_rst || wake_req)); // R2

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_rst && wake_req)); // R5

    AST_DEV_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |=> !dev_rst); // R5

    AST_TO_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rst || wake_req) |-> to_flag); // R5

    AST_WAKE_PAIRS_PCSP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req == pcsp_rst); // R6

    AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        to_flag |=> to_flag); // R7

    AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !(dev_rst || wake_req)); // R8

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
    parameter int               CNT_W   = 8,
    parameter int               PS_W    = 3,
    parameter int               KEY_W   = 4,
    parameter int               DIV_W   = 2,
    parameter logic [KEY_W-1:0] KEY_OFF = 4'b1010,
    parameter logic [PS_W-1:0]  PS_RST  = 3'b111
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_force_en,
    input  logic             cfg_pair_mode,
    input  logic [1:0]       cfg_src_sel,
    input  logic             xtal_tick,
    input  logic             rc_tick,
    input  logic             key_we,
    input  logic [KEY_W-1:0] key_wdata,
    input  logic             ps_we,
    input  logic [PS_W-1:0]  ps_wdata,
    input  logic             clr_single,
    input  logic             clr_first,
    input  logic             clr_second,
    input  logic             halt,
    input  logic             asleep,
    output logic             dev_rst,
    output logic             wake_req,
    output logic             pcsp_rst,
    output logic             to_flag
);

    logic            run;
    logic [PS_W-1:0] ps_sel;
    logic            tick;
    logic            clr_go;

    kwd_cfg_regs #(
        .KEY_W(KEY_W), .PS_W(PS_W), .KEY_OFF(KEY_OFF),
        .KEY_RST(KEY_OFF), .PS_RST(PS_RST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_force_en(cfg_force_en),
        .key_we(key_we), .key_wdata(key_wdata),
        .ps_we(ps_we), .ps_wdata(ps_wdata),
        .run(run), .ps_sel(ps_sel)
    );

    kwd_tick_sel #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .src_sel(cfg_src_sel),
        .xtal_tick(xtal_tick), .rc_tick(rc_tick), .asleep(asleep),
        .tick(tick)
    );

    kwd_clear_ctl u_clr (
        .clk(clk), .rst_n(rst_n), .run(run), .pair_mode(cfg_pair_mode),
        .clr_single(clr_single), .clr_a(clr_first), .clr_b(clr_second),
        .clr_go(clr_go)
    );

    kwd_count #(.CNT_W(CNT_W), .PS_W(PS_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .halt(halt),
        .clr_go(clr_go), .asleep(asleep), .ps_sel(ps_sel),
        .dev_rst(dev_rst), .wake_req(wake_req), .pcsp_rst(pcsp_rst),
        .to_flag(to_flag)
    );

endmodule

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/1ps
module sim_keyed_wdog;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_force_en = 1'b0, cfg_pair_mode = 1'b0;
    logic [1:0] cfg_src_sel = 2'b00;
    logic       xtal_tick = 1'b1, rc_tick = 1'b0;
    logic       key_we = 1'b0;
    logic [3:0] key_wdata = 4'd0;
    logic       ps_we = 1'b0;
    logic [2:0] ps_wdata = 3'd0;
    logic       clr_single = 1'b0, clr_first = 1'b0, clr_second = 1'b0;
    logic       halt = 1'b0, asleep = 1'b0;
    logic       dev_rst, wake_req, pcsp_rst, to_flag;

    always #2.5 clk = ~clk;

    keyed_wdog u0 (
        .clk(clk), .rst_n(rst_n), .cfg_force_en(cfg_force_en),
        .cfg_pair_mode(cfg_pair_mode), .cfg_src_sel(cfg_src_sel),
        .xtal_tick(xtal_tick), .rc_tick(rc_tick),
        .key_we(key_we), .key_wdata(key_wdata),
        .ps_we(ps_we), .ps_wdata(ps_wdata),
        .clr_single(clr_single), .clr_first(clr_first), .clr_second(clr_second),
        .halt(halt), .asleep(asleep),
        .dev_rst(dev_rst), .wake_req(wake_req), .pcsp_rst(pcsp_rst),
        .to_flag(to_flag)
    );

    int compared = 0, mismatched = 0;
    bit armed = 0;

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_key, m_ps, m_div, m_pre, m_cnt, m_last;
    int m_dev, m_wake, m_pcsp, m_to;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_key = 10; m_ps = 7; m_div = 0; m_pre = 0; m_cnt = 0; m_last = 0;
            m_dev = 0; m_wake = 0; m_pcsp = 0; m_to = 0;
        end else begin
            bit en, tk, clr, sys;
            en  = cfg_force_en || (m_key != 10);
            sys = (m_div == 3) && !asleep;
            m_div = (m_div + 1) % 4;
            case (cfg_src_sel)
                2'b00: tk = xtal_tick;
                2'b01: tk = sys;
                2'b10: tk = rc_tick;
                default: tk = 0;
            endcase
            clr = 0;
            if (en) begin
                if (!cfg_pair_mode) clr = clr_single;
                else if (clr_first != clr_second) begin
                    if (clr_first && m_last != 1) begin clr = 1; m_last = 1; end
                    if (clr_second && m_last != 2) begin clr = 1; m_last = 2; end
                end
            end
            m_dev = 0; m_wake = 0; m_pcsp = 0;
            if (!en || halt || clr) begin
                m_pre = 0; m_cnt = 0;
            end else if (tk) begin
                if (m_pre + 1 >= (1 << m_ps)) begin
                    m_pre = 0;
                    if (m_cnt == 255) begin
                        m_cnt = 0; m_to = 1;
                        if (asleep) begin m_wake = 1; m_pcsp = 1; end
                        else m_dev = 1;
                    end else m_cnt++;
                end else m_pre++;
            end
            if (key_we) m_key = key_wdata;
            if (ps_we)  m_ps  = ps_wdata;
        end
    end

    int n_dev = 0, n_wake = 0;
    always @(negedge clk) begin
        if (armed) begin
            chk("R5 dev_rst vs model", int'(dev_rst), m_dev);
            chk("R6 wake_req vs model", int'(wake_req), m_wake);
            chk("R6 pcsp_rst vs model", int'(pcsp_rst), m_pcsp);
            chk("R7 to_flag vs model", int'(to_flag), m_to);
        end
        if (dev_rst) n_dev++;
        if (wake_req) n_wake++;
    end

    task automatic go();
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input int which);
        go();
        case (which)
            0: clr_single = 1;
            1: clr_first = 1;
            2: clr_second = 1;
            3: halt = 1;
            default: begin clr_first = 1; clr_second = 1; end
        endcase
        go();
        clr_single = 0; clr_first = 0; clr_second = 0; halt = 0;
    endtask

    task automatic wr_key(input logic [3:0] v);
        go(); key_we = 1; key_wdata = v; go(); key_we = 0;
    endtask

    task automatic wr_ps(input logic [2:0] v);
        go(); ps_we = 1; ps_wdata = v; go(); ps_we = 0;
    endtask

    // halt, then count falling edges until dev_rst (sel=0) or wake_req (sel=1)
    task automatic measure(input int sel, input int limit, output int n);
        go(); halt = 1;
        @(negedge clk); #1; halt = 0;
        n = 0;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if ((sel == 0 && dev_rst) || (sel == 1 && wake_req)) break;
        end
    endtask

    initial begin
        int n, base, basew;
        fork
            forever begin @(negedge clk); #1; rc_tick = ~rc_tick; end
        join_none
        idle(3); #1; rst_n = 1; armed = 1;
        idle(1);
        chk("R7 reset dev_rst", int'(dev_rst), 0);
        chk("R7 reset to_flag", int'(to_flag), 0);

        // R2: stopped by reset key; strobes are no-ops
        cfg_pair_mode = 1;
        strobe(1);
        idle(300);
        chk("R2 no time-out while stopped", n_dev, 0);
        wr_ps(3'b000);
        wr_key(4'b0101);                  // R1 enable with preferred code
        idle(200);
        strobe(1);                        // R2/R10 tracker still accepts first strobe
        base = n_dev;
        idle(200);
        chk("R2 tracker untouched while stopped", n_dev - base, 0);

        // R4/R5: 256 ticks at ratio 1:1
        cfg_pair_mode = 0;
        measure(0, 3000, n);
        chk("R4 time-out edges at 1:1", n, 256);
        chk("R5 to_flag after time-out", int'(to_flag), 1);
        idle(1);
        chk("R5 dev_rst one cycle", int'(dev_rst), 0);
        idle(50);
        chk("R7 to_flag sticky", int'(to_flag), 1);

        // R9 single mode
        strobe(3);
        base = n_dev;
        for (int k = 0; k < 8; k++) begin strobe(0); idle(98); end
        chk("R9 clr_single keeps alive", n_dev - base, 0);
        base = n_dev;
        for (int k = 0; k < 4; k++) begin strobe(1); idle(98); end
        chk("R9 clr_first ignored", int'(n_dev - base > 0), 1);

        // R10 paired mode
        cfg_pair_mode = 1;
        strobe(3);
        base = n_dev;
        for (int k = 0; k < 8; k++) begin strobe(1 + (k % 2)); idle(98); end
        chk("R10 alternating keeps alive", n_dev - base, 0);
        base = n_dev;
        for (int k = 0; k < 5; k++) begin strobe(2); idle(98); end
        chk("R10 repeated strobe ignored", int'(n_dev - base > 0), 1);
        base = n_dev;
        for (int k = 0; k < 5; k++) begin strobe(0); idle(98); end
        chk("R10 clr_single ignored", int'(n_dev - base > 0), 1);
        base = n_dev;
        for (int k = 0; k < 5; k++) begin strobe(4); idle(98); end
        chk("R10 both strobes ignored", int'(n_dev - base > 0), 1);

        // R8 halt
        base = n_dev;
        for (int k = 0; k < 8; k++) begin strobe(3); idle(98); end
        chk("R8 halt keeps alive", n_dev - base, 0);

        // R6 asleep with crystal source
        go(); asleep = 1;
        base = n_dev;
        measure(1, 3000, n);
        chk("R6 wake edges asleep", n, 256);
        chk("R6 no dev_rst asleep", n_dev - base, 0);

        // R3 divided system clock stops asleep
        go(); cfg_src_sel = 2'b01;
        strobe(3);
        basew = n_wake;
        idle(1500);
        chk("R3 sys/4 silent asleep", n_wake - basew, 0);
        go(); asleep = 0;
        measure(0, 3000, n);
        chk("R3 sys/4 time-out window", int'(n >= 1021 && n <= 1024), 1);
        go(); cfg_src_sel = 2'b10;
        measure(0, 3000, n);
        chk("R3 rc time-out window", int'(n >= 511 && n <= 513), 1);
        go(); cfg_src_sel = 2'b11;
        strobe(3);
        base = n_dev;
        idle(600);
        chk("R3 no source no time-out", n_dev - base, 0);
        go(); cfg_src_sel = 2'b00;

        // R1 force enable overrides stop key
        go(); cfg_force_en = 1;
        wr_key(4'b1010);
        measure(0, 3000, n);
        chk("R1 forced run with stop key", n, 256);
        go(); cfg_force_en = 0;
        base = n_dev;
        idle(600);
        chk("R1 stop key stops timer", n_dev - base, 0);

        // R4 ratio 1:4
        wr_key(4'b0011);
        wr_ps(3'b010);
        measure(0, 3000, n);
        chk("R4 time-out edges at 1:4", n, 1024);

        // R7 asynchronous reset
        go(); rst_n = 0; #1;
        chk("R7 async reset clears to_flag", int'(to_flag), 0);
        idle(2); #1; rst_n = 1;
        base = n_dev;
        idle(600);
        chk("R1 key back to stop code after reset", n_dev - base, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule